// File: doc/BRIEF.md
# Host Byte-Stream Command Packet Decoder

This block sits behind a synchronous 8-bit FIFO bridge to a host, such as a USB-to-parallel converter, and turns the incoming byte stream into transactions on a simple register bus. Every packet starts with an 8-byte header: a reserved zero byte, a 32-bit address and a 24-bit word count. The top address bit chooses write or read. The next seven bits pick a back-end module. The low 24 bits give the register or start address inside that module. A write header is followed by its data words. For a read header, the block fetches the words over the bus and pushes them back to the host through the transmit FIFO.

The receive FIFO is show-ahead: `rx_data` is valid whenever `rx_avail` is high, and a byte is consumed in any cycle where `rx_pop` is high. The transmit FIFO takes `tx_data` in each cycle where `tx_push` is high. On the register bus, `bus_req` stays high until the back end answers with `bus_ack` in a cycle. For reads, `bus_rdata` is sampled in that same cycle.

The control is one state machine with these states. ST_HUNT waits for the reserved byte. ST_ADDR collects the four address bytes. ST_LEN collects the three length bytes. ST_DISPATCH picks the path. ST_WR_HI and ST_WR_LO take in one write word. ST_WR_BUS issues that word. ST_RD_BUS issues a read. ST_RD_HI and ST_RD_LO return the read word. The transitions are:
- ST_HUNT to ST_ADDR on a 0x00 byte.
- ST_ADDR to ST_LEN after its fourth byte.
- ST_LEN to ST_DISPATCH after its third byte.
- ST_DISPATCH to ST_HUNT on a zero count, to ST_WR_HI for a write, otherwise to ST_RD_BUS.
- ST_WR_HI to ST_WR_LO, and ST_WR_LO to ST_WR_BUS, on each byte taken.
- ST_WR_BUS on acknowledge: to ST_HUNT after the last word, otherwise back to ST_WR_HI.
- ST_RD_BUS to ST_RD_HI on acknowledge.
- ST_RD_HI to ST_RD_LO when the transmit FIFO has room.
- ST_RD_LO, when the transmit FIFO has room: to ST_HUNT after the last word, otherwise to ST_RD_BUS.

Top module: `hpd_decoder`

## Requirements
- R1: During and right after reset, `bus_req` and `tx_push` are low. With an empty receive FIFO, `rx_pop` is also low.
- R2: The header is taken in as follows, with each multi-byte field sent most significant byte first:
  - one byte 0x00;
  - four address bytes: bit 31 high means write and low means read, bits 30:24 appear on `bus_mod`, and bits 23:0 appear on `bus_reg`;
  - three bytes of word count.
- R3: While waiting for a packet, any byte other than 0x00 is consumed and dropped. Parsing restarts at the first 0x00.
- R4: A write packet carries count×2 data bytes, high byte first. Each pair is issued as one bus transaction with `bus_we`=1 and the assembled word on `bus_wdata`.
- R5: A read packet has no payload. For each word the block runs one bus transaction with `bus_we`=0. After the acknowledge, it pushes the returned word to the host as two bytes, high byte first. No byte is pushed while a bus request is open.
- R6: A count of zero produces no bus transaction and no reply byte. The packet that follows is decoded normally.
- R7: A bus request stays high, with `bus_we`, `bus_mod`, `bus_reg` and `bus_wdata` unchanged, until `bus_ack`. The next word is issued only after the acknowledge, with at least one idle cycle in between.
- R8: `tx_push` is never high while `tx_full` is high. The reply waits, and no further bus read is started, until room appears.
- R9: `rx_pop` is only high when `rx_avail` is high. Gaps in the receive stream, in the header or the payload, leave the result unchanged.
- R10: Every word of a multi-word transfer uses the same `bus_mod` and `bus_reg` taken from the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_avail | input | 1 | Receive FIFO holds at least one byte |
| rx_pop | output | 1 | Consume the head byte this cycle |
| tx_data | output | 8 | Byte to the transmit FIFO |
| tx_push | output | 1 | Write `tx_data` into the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO has no room |
| bus_req | output | 1 | Register bus request, held until acknowledge |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_mod | output | 7 | Module number |
| bus_reg | output | 24 | Register or start address in the module |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Back end completes the transaction |

## Verification
A header byte counter that is off by one shifts every later field. The first bus request would then show the wrong module or register, or a write word with its bytes swapped, within one word time of the header. A word counter that is wrong shows up at the end of a packet. It gives one transaction too many or too few, or it swallows the next packet's reserved byte, so the following packet decodes badly. A state machine that leaves its wait states early shows up in the same cycle. It pops an empty FIFO, pushes into a full one, or drops a request before its acknowledge.

// File: rtl/hpd_pkg.sv
`timescale 1ns/1ps
package hpd_pkg;
    parameter int BYTE_W  = 8;
    parameter int WORD_W  = 16;
    parameter int MOD_W   = 7;
    parameter int REG_W   = 24;
    parameter int LEN_W   = 24;
    parameter logic [7:0] RESV_BYTE = 8'h00;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_ADDR,
        ST_LEN,
        ST_DISPATCH,
        ST_WR_HI,
        ST_WR_LO,
        ST_WR_BUS,
        ST_RD_BUS,
        ST_RD_HI,
        ST_RD_LO
    } hpd_state_e;
endpackage

// File: rtl/hpd_hdr_shift.sv
`timescale 1ns/1ps
module hpd_hdr_shift #(
    parameter int BYTE_W = 8,
    parameter int HDR_W  = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [HDR_W-1:0]  hdr_q
);
    // Header bytes enter at the low end, so the first byte ends up on top.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q <= '0;
        end else if (shift_en) begin
            hdr_q <= {hdr_q[HDR_W-BYTE_W-1:0], byte_in};
        end
    end
endmodule

// File: rtl/hpd_word_counter.sv
`timescale 1ns/1ps
module hpd_word_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign last = (left_q == CNT_W'(1));
endmodule

// File: rtl/hpd_word_pack.sv
`timescale 1ns/1ps
module hpd_word_pack #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WORD_W/BYTE_W-1:0] lane_load,
    input  logic [BYTE_W-1:0]        byte_in,
    output logic [WORD_W-1:0]        word_q
);
    localparam int LANES = WORD_W / BYTE_W;

    logic [BYTE_W-1:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (lane_load[g]) begin
                lane_q[g] <= byte_in;
            end
        end
    end

    always_comb begin
        word_q = '0;
        for (int i = 0; i < LANES; i++) begin
            word_q[i*BYTE_W +: BYTE_W] = lane_q[i];
        end
    end
endmodule

// File: rtl/hpd_tx_ser.sv
`timescale 1ns/1ps
module hpd_tx_ser #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16,
    parameter int SEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic [SEL_W-1:0]  lane_sel,
    output logic [BYTE_W-1:0] byte_out
);
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= word_in;
        end
    end

    assign byte_out = word_q[lane_sel*BYTE_W +: BYTE_W];
endmodule

// File: rtl/hpd_decoder.sv
`timescale 1ns/1ps
module hpd_decoder #(
    parameter int BYTE_W = hpd_pkg::BYTE_W,
    parameter int WORD_W = hpd_pkg::WORD_W,
    parameter int MOD_W  = hpd_pkg::MOD_W,
    parameter int REG_W  = hpd_pkg::REG_W,
    parameter int LEN_W  = hpd_pkg::LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_avail,
    output logic              rx_pop,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_push,
    input  logic              tx_full,
    output logic              bus_req,
    output logic              bus_we,
    output logic [MOD_W-1:0]  bus_mod,
    output logic [REG_W-1:0]  bus_reg,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    import hpd_pkg::*;

    localparam int ADDR_W     = 1 + MOD_W + REG_W;
    localparam int HDR_W      = ADDR_W + LEN_W;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int LEN_BYTES  = LEN_W / BYTE_W;
    localparam int LANES      = WORD_W / BYTE_W;
    localparam int SEL_W      = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int FC_W       = $clog2(ADDR_BYTES + LEN_BYTES);
    localparam logic [FC_W-1:0] ADDR_END = FC_W'(ADDR_BYTES - 1);
    localparam logic [FC_W-1:0] LEN_END  = FC_W'(LEN_BYTES - 1);
    localparam logic [SEL_W-1:0] SEL_HI  = SEL_W'(LANES - 1);
    localparam logic [SEL_W-1:0] SEL_LO  = '0;

    hpd_state_e state_q, state_nx;

    logic [FC_W-1:0]   fld_cnt_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [ADDR_W-1:0] addr_f;
    logic [LEN_W-1:0]  len_f;
    logic              dir_wr;
    logic              len_zero;
    logic              word_last;

    logic              hdr_shift;
    logic [LANES-1:0]  lane_load;
    logic              cnt_load;
    logic              cnt_dec;
    logic              ser_load;
    logic [SEL_W-1:0]  ser_sel;

    assign addr_f   = hdr_q[HDR_W-1 -: ADDR_W];
    assign len_f    = hdr_q[LEN_W-1:0];
    assign dir_wr   = addr_f[ADDR_W-1];
    assign len_zero = (len_f == '0);
    assign bus_mod  = addr_f[REG_W +: MOD_W];
    assign bus_reg  = addr_f[REG_W-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Byte position inside the address and length fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_cnt_q <= '0;
        end else if (state_q == ST_ADDR && rx_pop) begin
            fld_cnt_q <= (fld_cnt_q == ADDR_END) ? '0 : fld_cnt_q + FC_W'(1);
        end else if (state_q == ST_LEN && rx_pop) begin
            fld_cnt_q <= (fld_cnt_q == LEN_END) ? '0 : fld_cnt_q + FC_W'(1);
        end else if (state_q == ST_HUNT) begin
            fld_cnt_q <= '0;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (rx_avail && rx_data == RESV_BYTE) state_nx = ST_ADDR;
            end
            ST_ADDR: begin
                if (rx_avail && fld_cnt_q == ADDR_END) state_nx = ST_LEN;
            end
            ST_LEN: begin
                if (rx_avail && fld_cnt_q == LEN_END) state_nx = ST_DISPATCH;
            end
            ST_DISPATCH: begin
                if (len_zero)    state_nx = ST_HUNT;
                else if (dir_wr) state_nx = ST_WR_HI;
                else             state_nx = ST_RD_BUS;
            end
            ST_WR_HI: begin
                if (rx_avail) state_nx = ST_WR_LO;
            end
            ST_WR_LO: begin
                if (rx_avail) state_nx = ST_WR_BUS;
            end
            ST_WR_BUS: begin
                if (bus_ack) state_nx = word_last ? ST_HUNT : ST_WR_HI;
            end
            ST_RD_BUS: begin
                if (bus_ack) state_nx = ST_RD_HI;
            end
            ST_RD_HI: begin
                if (!tx_full) state_nx = ST_RD_LO;
            end
            ST_RD_LO: begin
                if (!tx_full) state_nx = word_last ? ST_HUNT : ST_RD_BUS;
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    // Output and datapath control
    always_comb begin
        rx_pop    = 1'b0;
        hdr_shift = 1'b0;
        lane_load = '0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        ser_load  = 1'b0;
        ser_sel   = SEL_LO;
        tx_push   = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                rx_pop = rx_avail;
            end
            ST_ADDR, ST_LEN: begin
                rx_pop    = rx_avail;
                hdr_shift = rx_avail;
            end
            ST_DISPATCH: begin
                cnt_load = 1'b1;
            end
            ST_WR_HI: begin
                rx_pop           = rx_avail;
                lane_load[LANES-1] = rx_avail;
            end
            ST_WR_LO: begin
                rx_pop       = rx_avail;
                lane_load[0] = rx_avail;
            end
            ST_WR_BUS: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
                cnt_dec = bus_ack;
            end
            ST_RD_BUS: begin
                bus_req  = 1'b1;
                ser_load = bus_ack;
            end
            ST_RD_HI: begin
                ser_sel = SEL_HI;
                tx_push = !tx_full;
            end
            ST_RD_LO: begin
                ser_sel = SEL_LO;
                tx_push = !tx_full;
                cnt_dec = !tx_full;
            end
            default: begin
                rx_pop = 1'b0;
            end
        endcase
    end

    hpd_hdr_shift #(
        .BYTE_W (BYTE_W),
        .HDR_W  (HDR_W)
    ) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (hdr_shift),
        .byte_in  (rx_data),
        .hdr_q    (hdr_q)
    );

    hpd_word_counter #(
        .CNT_W (LEN_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (len_f),
        .dec      (cnt_dec),
        .last     (word_last)
    );

    hpd_word_pack #(
        .BYTE_W (BYTE_W),
        .WORD_W (WORD_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_load (lane_load),
        .byte_in   (rx_data),
        .word_q    (bus_wdata)
    );

    hpd_tx_ser #(
        .BYTE_W (BYTE_W),
        .WORD_W (WORD_W),
        .SEL_W  (SEL_W)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ser_load),
        .word_in  (bus_rdata),
        .lane_sel (ser_sel),
        .byte_out (tx_data)
    );
endmodule

// File: rtl/hpd_decoder_chk.sv
`timescale 1ns/1ps
module hpd_decoder_chk #(
    parameter int WORD_W = hpd_pkg::WORD_W,
    parameter int MOD_W  = hpd_pkg::MOD_W,
    parameter int REG_W  = hpd_pkg::REG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_avail,
    input logic              rx_pop,
    input logic              tx_push,
    input logic              tx_full,
    input logic              bus_req,
    input logic              bus_we,
    input logic [MOD_W-1:0]  bus_mod,
    input logic [REG_W-1:0]  bus_reg,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              bus_ack
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!bus_req && !tx_push) else $error("outputs active in reset"); // R1
        end
    end

    AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n) rx_pop |-> rx_avail); // R9
    AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n) tx_push |-> !tx_full); // R8
    AST_TX_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) tx_push |-> !bus_req); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (bus_req && !bus_ack) |=> bus_req); // R7
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (bus_req && !bus_ack) |=> ($stable(bus_we) && $stable(bus_mod) && $stable(bus_reg) && $stable(bus_wdata))); // R7
    AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n) (bus_req && bus_ack) |=> !bus_req); // R7
endmodule

bind hpd_decoder hpd_decoder_chk u_chk (.*);

// File: tb/hpd_decoder_tb.sv
`timescale 1ns/1ps
module hpd_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_avail;
    logic        rx_pop;
    logic [7:0]  tx_data;
    logic        tx_push;
    logic        tx_full = 1'b0;
    logic        bus_req;
    logic        bus_we;
    logic [6:0]  bus_mod;
    logic [23:0] bus_reg;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_ack;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Receive FIFO model
    logic [7:0] fmem [0:255];
    int wp = 0;
    int rp = 0;
    assign rx_avail = (rp != wp);
    assign rx_data  = fmem[rp[7:0]];
    always @(posedge clk) if (rx_pop) rp <= rp + 1;

    // Back-end responder
    int lat = 0;
    int wait_cnt = 0;
    int seq = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack <= 1'b0; wait_cnt <= 0; seq <= 0;
        end else if (bus_ack) begin
            bus_ack <= 1'b0; wait_cnt <= 0; seq <= seq + 1;
        end else if (bus_req) begin
            if (wait_cnt >= lat) bus_ack <= 1'b1;
            else wait_cnt <= wait_cnt + 1;
        end
    end
    assign bus_rdata = 16'h1234 + 16'(seq) * 16'h1111;

    // Logs sampled at the falling edge
    logic        we_l  [0:63];
    logic [6:0]  mod_l [0:63];
    logic [23:0] reg_l [0:63];
    logic [15:0] wd_l  [0:63];
    logic [7:0]  tx_l  [0:63];
    int n_txn = 0;
    int n_tx = 0;
    always @(negedge clk) begin
        if (rst_n && bus_req && bus_ack) begin
            we_l[n_txn] <= bus_we; mod_l[n_txn] <= bus_mod;
            reg_l[n_txn] <= bus_reg; wd_l[n_txn] <= bus_wdata;
            n_txn <= n_txn + 1;
        end
        if (rst_n && tx_push) begin
            tx_l[n_tx] <= tx_data;
            n_tx <= n_tx + 1;
        end
    end

    hpd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_avail(rx_avail), .rx_pop(rx_pop),
        .tx_data(tx_data), .tx_push(tx_push), .tx_full(tx_full),
        .bus_req(bus_req), .bus_we(bus_we), .bus_mod(bus_mod), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input int gap);
        @(negedge clk);
        fmem[wp[7:0]] = b;
        wp = wp + 1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic put_hdr(input logic [31:0] addr, input logic [23:0] len, input int gap);
        put(8'h00, gap);
        for (int i = 3; i >= 0; i--) put(addr[i*8 +: 8], gap);
        for (int i = 2; i >= 0; i--) put(len[i*8 +: 8], gap);
    endtask

    task automatic settle();
        while (rp != wp) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    function automatic logic [15:0] rd_word(input int k);
        return 16'h1234 + 16'(k) * 16'h1111;
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 bus_req in reset", {31'd0, bus_req}, 0);
        chk("R1 tx_push in reset", {31'd0, tx_push}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 bus_req after reset", {31'd0, bus_req}, 0);
        chk("R1 rx_pop on empty fifo", {31'd0, rx_pop}, 0);
    endtask

    task automatic t_single_write();
        int b = n_txn;
        lat = 0;
        put_hdr(32'h8400_0005, 24'd1, 0);
        put(8'h33, 0); put(8'hAA, 0);
        settle();
        chk("R4 write txn count", n_txn - b, 1);
        chk("R2 write direction", {31'd0, we_l[b]}, 1);
        chk("R2 module", {25'd0, mod_l[b]}, 4);
        chk("R2 register", {8'd0, reg_l[b]}, 5);
        chk("R4 write data", {16'd0, wd_l[b]}, 32'h33AA);
    endtask

    task automatic t_single_read();
        int b = n_txn;
        int tb = n_tx;
        lat = 2;
        put_hdr(32'h0400_0005, 24'd1, 0);
        settle();
        chk("R5 read txn count", n_txn - b, 1);
        chk("R5 read direction", {31'd0, we_l[b]}, 0);
        chk("R2 read module/reg", {1'b0, mod_l[b], reg_l[b]}, {1'b0, 7'd4, 24'd5});
        chk("R5 reply byte count", n_tx - tb, 2);
        chk("R5 reply high byte", {24'd0, tx_l[tb]}, {24'd0, rd_word(b)[15:8]});
        chk("R5 reply low byte", {24'd0, tx_l[tb+1]}, {24'd0, rd_word(b)[7:0]});
    endtask

    task automatic t_resync();
        int b = n_txn;
        put(8'h5A, 0); put(8'hFF, 1); put(8'h84, 0);
        put_hdr(32'h8A00_0042, 24'd1, 0);
        put(8'hBE, 0); put(8'hEF, 0);
        settle();
        chk("R3 txn count after junk", n_txn - b, 1);
        chk("R3 fields after junk", {wd_l[b], 1'b0, mod_l[b], reg_l[b][7:0]}, {16'hBEEF, 1'b0, 7'h0A, 8'h42});
    endtask

    task automatic t_zero_len();
        int b = n_txn;
        int tb = n_tx;
        put_hdr(32'h8200_0010, 24'd0, 0);
        settle();
        chk("R6 zero count no txn", n_txn - b, 0);
        chk("R6 zero count no reply", n_tx - tb, 0);
        put_hdr(32'h0300_0077, 24'd1, 0);
        settle();
        chk("R6 next packet txn", n_txn - b, 1);
        chk("R6 next packet register", {8'd0, reg_l[b]}, 32'h77);
        chk("R6 next packet reply", n_tx - tb, 2);
    endtask

    task automatic t_multi_write();
        int b = n_txn;
        logic [15:0] w [3] = '{16'h1111, 16'h2222, 16'hABCD};
        lat = 3;
        put_hdr(32'h9512_3456, 24'd3, 2);
        foreach (w[i]) begin
            put(w[i][15:8], 3);
            put(w[i][7:0], 1);
        end
        settle();
        chk("R9 multi write txn count", n_txn - b, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R4 multi write word", {16'd0, wd_l[b+i]}, {16'd0, w[i]});
            chk("R10 module/reg held", {1'b0, mod_l[b+i], reg_l[b+i]}, {1'b0, 7'h15, 24'h123456});
        end
    endtask

    task automatic t_multi_read();
        int b = n_txn;
        int tb = n_tx;
        lat = 1;
        tx_full = 1'b1;
        put_hdr(32'h0223_4567, 24'd2, 0);
        settle();
        chk("R8 nothing pushed while full", n_tx - tb, 0);
        chk("R8 one read then wait", n_txn - b, 1);
        @(negedge clk); tx_full = 1'b0;
        @(negedge clk); tx_full = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 one byte in open window", n_tx - tb, 1);
        tx_full = 1'b0;
        settle();
        chk("R5 two reads done", n_txn - b, 2);
        chk("R10 second read reg", {8'd0, reg_l[b+1]}, 32'h234567);
        for (int i = 0; i < 2; i++) begin
            chk("R5 multi reply hi", {24'd0, tx_l[tb+2*i]}, {24'd0, rd_word(b+i)[15:8]});
            chk("R5 multi reply lo", {24'd0, tx_l[tb+2*i+1]}, {24'd0, rd_word(b+i)[7:0]});
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single_write();
        t_single_read();
        t_resync();
        t_zero_len();
        t_multi_write();
        t_multi_read();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule